// File: doc/BRIEF.md
# Prioritized Memory Region Protection Filter

This block is the access filter of a small memory protection unit. It holds three programmable regions. Each region has a range register, which gives a base address and a size, and a policy register, which gives four permission bits. For each request the filter takes a 16-bit address, a read/write flag and a privilege flag. One clock later it answers with grant or deny.

Regions may overlap. By default the region with the lowest index that contains the address decides the outcome. Region 2 can be programmed by unprivileged software, so this rule stops it from blocking or widening access to addresses that regions 0 and 1 cover. A strict mode can be selected on each request instead. In strict mode an access is granted only if every region that contains the address allows it. The configuration write port checks the writer's privilege against the target region. A write that is not allowed is dropped and reported with a one-cycle error pulse.

Top module: `region_guard`

## Requirements
- R1: After reset every region has size 0 and policy 0, `rsp_valid`, `rsp_grant` and `cfg_err` are low, and no address matches any region.
- R2: An address A matches a region when base <= A < base + size. The sum is formed in 17 bits, so a region never wraps past 0xFFFF to low addresses. A region of size 0 matches nothing.
- R3: Regions 0 and 1 accept a write only when `cfg_priv` is 1. A write to them with `cfg_priv` 0, or a write with `cfg_sel` 3, changes no register and drives `cfg_err` high for exactly the cycle after the write edge.
- R4: Region 2 accepts writes at either privilege level, and such writes never raise `cfg_err`.
- R5: A write with `cfg_kind` 0 loads the range register: the base from `cfg_wdata[15:0]` and the size from `cfg_wdata[31:16]`. A write with `cfg_kind` 1 loads the policy from `cfg_wdata[3:0]`. The new values apply to requests from the cycle after the write edge.
- R6: Policy bits: bit 0 allows unprivileged reads, bit 1 allows unprivileged writes, bit 2 allows privileged reads and bit 3 allows privileged writes (`req_write` 1 means write, `req_priv` 1 means privileged).
- R7: With `strict_mode` 0, the policy of the lowest-numbered region that matches the address alone decides the grant.
- R8: With `strict_mode` 1, the access is granted only if every matching region allows it.
- R9: An address that matches no region is granted to privileged requests and denied to unprivileged ones, in both modes.
- R10: `rsp_valid` is `req_valid` delayed by one clock. `rsp_grant` carries the decision for the request of the previous cycle and is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target region index |
| cfg_kind | input | 1 | 0 selects the range register, 1 selects the policy register |
| cfg_wdata | input | 32 | Write data |
| cfg_priv | input | 1 | Privilege level of the configuration writer |
| cfg_err | output | 1 | One-cycle pulse after a rejected write |
| req_valid | input | 1 | Access request present |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_priv | input | 1 | 1 for a privileged requester |
| strict_mode | input | 1 | 1 requires all matching regions to agree |
| rsp_valid | output | 1 | Decision present |
| rsp_grant | output | 1 | 1 grants the access of the previous cycle |

## Verification
The assertions check on every cycle the parts of the block that can be seen locally. These are the one-cycle response timing, the rule that an unmatched address is decided by privilege alone, and the write-lock rule: a rejected write leaves region 0 unchanged and always causes an error pulse, and no error pulse appears without a write. The bench's reference model covers what needs the whole region state. It checks that the lowest-index priority and the all-agree mode produce the right outcome where regions overlap, the range edges at base and base+size, the non-wrapping top of the address space, size-zero regions, and the random mixes of programming and requests.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

   // Register kind selected by a configuration write
   typedef enum logic {
      REG_RANGE  = 1'b0,
      REG_POLICY = 1'b1
   } reg_kind_e;

   // Width of a policy word and positions of its permission bits
   localparam int POL_W        = 4;
   localparam int POL_USR_RD   = 0;
   localparam int POL_USR_WR   = 1;
   localparam int POL_PRV_RD   = 2;
   localparam int POL_PRV_WR   = 3;

   // Select the permission bit for a requester level and direction
   function automatic logic [1:0] perm_index(input logic priv, input logic is_write);
      return {priv, is_write};
   endfunction

endpackage

// File: rtl/rg_cfg_regs.sv
module rg_cfg_regs
   import region_guard_pkg::*;
#(
   parameter int NUM_REGIONS  = 3,
   parameter int PRIV_REGIONS = 2,
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 32,
   parameter int SEL_W        = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [SEL_W-1:0]                    wr_sel,
   input  logic                                wr_kind,
   input  logic [DATA_W-1:0]                   wr_data,
   input  logic                                wr_priv,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_o,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  size_o,
   output logic [NUM_REGIONS-1:0][POL_W-1:0]   pol_o,
   output logic                                err_o
);

   localparam logic [SEL_W-1:0] LAST_SEL   = SEL_W'(NUM_REGIONS - 1);
   localparam logic [SEL_W-1:0] LOCKED_END = SEL_W'(PRIV_REGIONS);

   logic sel_valid;
   logic sel_locked;
   logic reject;

   assign sel_valid  = (wr_sel <= LAST_SEL);
   assign sel_locked = (wr_sel < LOCKED_END);
   assign reject     = wr_en && (!sel_valid || (sel_locked && !wr_priv));

   always_ff @(posedge clk) begin
      if (!rst_n) err_o <= 1'b0;
      else        err_o <= reject;
   end

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      localparam bit NEEDS_PRIV = (g < PRIV_REGIONS);
      logic take;

      if (NEEDS_PRIV) begin : g_locked
         assign take = wr_en && (wr_sel == SEL_W'(g)) && wr_priv;
      end else begin : g_open
         assign take = wr_en && (wr_sel == SEL_W'(g));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[g] <= '0;
            size_o[g] <= '0;
            pol_o[g]  <= '0;
         end else if (take) begin
            if (wr_kind == REG_RANGE) begin
               base_o[g] <= wr_data[ADDR_W-1:0];
               size_o[g] <= wr_data[2*ADDR_W-1:ADDR_W];
            end else begin
               pol_o[g]  <= wr_data[POL_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/rg_range_match.sv
module rg_range_match #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] size,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   logic [ADDR_W:0] limit;
   logic            above_base;
   logic            below_limit;

   assign limit       = {1'b0, base} + {1'b0, size};
   assign above_base  = (addr >= base);
   assign below_limit = ({1'b0, addr} < limit);
   assign hit         = (size != '0) && above_base && below_limit;

endmodule

// File: rtl/rg_resolve.sv
module rg_resolve #(
   parameter int NUM_REGIONS = 3,
   parameter bit HAS_STRICT  = 1'b1
) (
   input  logic [NUM_REGIONS-1:0] hit,
   input  logic [NUM_REGIONS-1:0] allow,
   input  logic                   strict,
   input  logic                   priv,
   output logic                   grant
);

   logic any_hit;
   logic prio_grant;

   assign any_hit = |hit;

   // Walk from the highest index down so the lowest matching index wins
   always_comb begin
      prio_grant = priv;
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
         if (hit[i]) prio_grant = allow[i];
      end
   end

   if (HAS_STRICT) begin : g_strict
      logic all_agree;
      always_comb begin
         all_agree = 1'b1;
         for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i] && !allow[i]) all_agree = 1'b0;
         end
      end
      assign grant = strict ? (any_hit ? all_agree : priv) : prio_grant;
   end else begin : g_prio_only
      logic unused_strict;
      assign unused_strict = strict;
      assign grant = prio_grant;
   end

endmodule

// File: rtl/region_guard.sv
module region_guard
   import region_guard_pkg::*;
#(
   parameter int NUM_REGIONS  = 3,
   parameter int PRIV_REGIONS = 2,
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 32,
   parameter bit HAS_STRICT   = 1'b1,
   localparam int SEL_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic              cfg_kind,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_priv,
   output logic              cfg_err,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_priv,
   input  logic              strict_mode,
   output logic              rsp_valid,
   output logic              rsp_grant
);

   if (DATA_W < 2 * ADDR_W) begin : g_bad_data_w
      $error("region_guard: DATA_W must hold base and size");
   end
   if (PRIV_REGIONS > NUM_REGIONS) begin : g_bad_priv
      $error("region_guard: PRIV_REGIONS exceeds NUM_REGIONS");
   end
   if (NUM_REGIONS < 1) begin : g_bad_num
      $error("region_guard: need at least one region");
   end

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
   logic [NUM_REGIONS-1:0][ADDR_W-1:0] size_q;
   logic [NUM_REGIONS-1:0][POL_W-1:0]  pol_q;
   logic [NUM_REGIONS-1:0]             hit_vec;
   logic [NUM_REGIONS-1:0]             allow_vec;
   logic [1:0]                         perm_sel;
   logic                               decide;

   rg_cfg_regs #(
      .NUM_REGIONS (NUM_REGIONS),
      .PRIV_REGIONS(PRIV_REGIONS),
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .SEL_W       (SEL_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_sel (cfg_sel),
      .wr_kind(cfg_kind),
      .wr_data(cfg_wdata),
      .wr_priv(cfg_priv),
      .base_o (base_q),
      .size_o (size_q),
      .pol_o  (pol_q),
      .err_o  (cfg_err)
   );

   assign perm_sel = perm_index(req_priv, req_write);

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
      rg_range_match #(.ADDR_W(ADDR_W)) u_match (
         .base(base_q[g]),
         .size(size_q[g]),
         .addr(req_addr),
         .hit (hit_vec[g])
      );
      assign allow_vec[g] = pol_q[g][perm_sel];
   end

   rg_resolve #(
      .NUM_REGIONS(NUM_REGIONS),
      .HAS_STRICT (HAS_STRICT)
   ) u_resolve (
      .hit   (hit_vec),
      .allow (allow_vec),
      .strict(strict_mode),
      .priv  (req_priv),
      .grant (decide)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= req_valid && decide;
      end
   end

endmodule

// File: rtl/region_guard_checker.sv
module region_guard_checker #(
   parameter int NUM_REGIONS  = 3,
   parameter int PRIV_REGIONS = 2,
   parameter int ADDR_W       = 16,
   parameter int SEL_W        = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_we,
   input logic [SEL_W-1:0]       cfg_sel,
   input logic                   cfg_priv,
   input logic                   cfg_err,
   input logic                   req_valid,
   input logic                   req_priv,
   input logic                   rsp_valid,
   input logic                   rsp_grant,
   input logic [NUM_REGIONS-1:0] hit_vec,
   input logic [ADDR_W-1:0]      r0_base,
   input logic [ADDR_W-1:0]      r0_size,
   input logic [3:0]             r0_pol
);

   localparam logic [SEL_W-1:0] LOCKED_END = SEL_W'(PRIV_REGIONS);
   localparam logic [SEL_W-1:0] REGION_END = SEL_W'(NUM_REGIONS);

   p_locked_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv && cfg_sel < LOCKED_END) |=> cfg_err);

   p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv && cfg_sel == '0) |=>
         ($stable(r0_base) && $stable(r0_size) && $stable(r0_pol)));

   p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_we));

   p_open_noerr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel >= LOCKED_END && cfg_sel < REGION_END) |=> !cfg_err);

   p_rsp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_grant));

   p_nomatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit_vec == '0) |=> (rsp_grant == $past(req_priv)));

endmodule

bind region_guard region_guard_checker #(
   .NUM_REGIONS (NUM_REGIONS),
   .PRIV_REGIONS(PRIV_REGIONS),
   .ADDR_W      (ADDR_W),
   .SEL_W       (SEL_W)
) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_sel  (cfg_sel),
   .cfg_priv (cfg_priv),
   .cfg_err  (cfg_err),
   .req_valid(req_valid),
   .req_priv (req_priv),
   .rsp_valid(rsp_valid),
   .rsp_grant(rsp_grant),
   .hit_vec  (hit_vec),
   .r0_base  (base_q[0]),
   .r0_size  (size_q[0]),
   .r0_pol   (pol_q[0])
);

// File: tb/region_guard_test.sv
`timescale 1ns/1ps
module region_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_kind = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_priv = 1'b0;
   logic        cfg_err;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_priv = 1'b0;
   logic        strict_mode = 1'b0;
   logic        rsp_valid;
   logic        rsp_grant;

   int checks = 0;
   int errors = 0;

   // Reference state
   int m_base [3];
   int m_size [3];
   int m_pol  [3];

   always #2 clk = ~clk;

   region_guard uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_kind(cfg_kind),
      .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv), .cfg_err(cfg_err),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_priv(req_priv), .strict_mode(strict_mode),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant)
   );

   function automatic bit model_hit(int r, int a);
      return (m_size[r] != 0) && (a >= m_base[r]) && (a < m_base[r] + m_size[r]);
   endfunction

   function automatic bit model_decide(int a, bit wr, bit pv, bit strict);
      int  bitpos = (pv ? 2 : 0) + (wr ? 1 : 0);
      bit  found = 0;
      bit  res = pv;
      bit  all_ok = 1;
      for (int r = 0; r < 3; r++) begin
         if (model_hit(r, a)) begin
            bit ok = m_pol[r][bitpos];
            if (!found) res = ok;
            found = 1;
            if (!ok) all_ok = 0;
         end
      end
      if (strict && found) return all_ok;
      return res;
   endfunction

   // One clock: predict from current inputs, advance model, compare after edge
   task automatic step(string tag);
      bit e_valid = req_valid;
      bit e_grant = req_valid && model_decide(int'(req_addr), req_write, req_priv, strict_mode);
      bit e_err   = 1'b0;
      if (cfg_we) begin
         int s = int'(cfg_sel);
         if (s >= 3 || (s < 2 && !cfg_priv)) e_err = 1'b1;
         else if (cfg_kind == 1'b0) begin
            m_base[s] = int'(cfg_wdata[15:0]);
            m_size[s] = int'(cfg_wdata[31:16]);
         end else m_pol[s] = int'(cfg_wdata[3:0]);
      end
      @(posedge clk);
      #1;
      checks++;
      if (rsp_valid !== e_valid || rsp_grant !== e_grant || cfg_err !== e_err) begin
         errors++;
         $display("FAIL %s: valid/grant/err actual %0b/%0b/%0b expected %0b/%0b/%0b",
                  tag, rsp_valid, rsp_grant, cfg_err, e_valid, e_grant, e_err);
      end
   endtask

   task automatic idle();
      cfg_we = 0; req_valid = 0;
   endtask

   task automatic wr(int sel, bit kind, logic [31:0] data, bit pv, string tag);
      req_valid = 0;
      cfg_we = 1; cfg_sel = 2'(sel); cfg_kind = kind; cfg_wdata = data; cfg_priv = pv;
      step(tag);
      idle();
   endtask

   task automatic rq(logic [15:0] a, bit w, bit pv, bit strict, string tag);
      cfg_we = 0;
      req_valid = 1; req_addr = a; req_write = w; req_priv = pv; strict_mode = strict;
      step(tag);
      idle();
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int r = 0; r < 3; r++) begin m_base[r] = 0; m_size[r] = 0; m_pol[r] = 0; end
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet in reset
      checks++;
      if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || cfg_err !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset outputs actual %0b%0b%0b expected 000", rsp_valid, rsp_grant, cfg_err);
      end
      rst_n = 1'b1;
      step("R1 idle");
      // R1/R9: nothing matches after reset
      rq(16'h0100, 0, 1, 0, "R1 priv read no region");
      rq(16'h0100, 0, 0, 0, "R9 unpriv read no region");
      // R3: unprivileged write to region 0 dropped, then proved by request
      wr(0, 0, 32'h1000_0000, 0, "R3 locked range write");
      wr(0, 1, 32'h0000_0000, 0, "R3 locked policy write");
      rq(16'h0100, 0, 1, 0, "R3 region0 still empty");
      wr(3, 0, 32'h1000_0000, 1, "R3 invalid index");
      // R5/R6: program regions
      wr(0, 0, 32'h1000_1000, 1, "R5 region0 range");
      wr(0, 1, 32'h0000_000F, 1, "R6 region0 policy");
      wr(1, 0, 32'h1000_1800, 1, "R5 region1 range");
      wr(1, 1, 32'h0000_0005, 1, "R6 region1 policy");
      wr(2, 0, 32'h8000_0800, 0, "R4 region2 range unpriv");
      wr(2, 1, 32'h0000_0000, 0, "R4 region2 policy unpriv");
      // R7 priority
      rq(16'h1200, 1, 0, 0, "R7 region0 over region2");
      rq(16'h1900, 1, 1, 0, "R7 region0 over region1");
      rq(16'h2100, 0, 1, 0, "R7 region1 read over region2");
      rq(16'h2100, 1, 1, 0, "R6 region1 denies write");
      rq(16'h0900, 0, 1, 0, "R7 region2 only");
      // R8 strict
      rq(16'h1200, 1, 0, 1, "R8 strict denied by region2");
      rq(16'h1900, 0, 1, 1, "R8 strict denied by region2 read");
      rq(16'h8900, 0, 0, 1, "R9 strict no match unpriv");
      rq(16'h8900, 1, 1, 1, "R9 strict no match priv");
      // R2 boundaries
      rq(16'h0FFF, 0, 1, 0, "R2 below region0 base");
      rq(16'h1000, 0, 1, 0, "R2 region0 base");
      rq(16'h27FF, 0, 1, 0, "R2 last of region1");
      rq(16'h87FF, 0, 1, 0, "R2 last of region2");
      rq(16'h8800, 0, 1, 0, "R2 region2 end excluded");
      // R2 no wrap and size zero
      wr(2, 0, 32'h0200_FF00, 1, "R4 region2 priv write");
      rq(16'hFFFF, 0, 1, 0, "R2 top address in region");
      rq(16'h0050, 0, 1, 0, "R2 no wrap to low");
      wr(1, 0, 32'h0000_1800, 1, "R5 region1 size zero");
      rq(16'h2100, 0, 1, 0, "R2 size zero matches nothing");
      // R10 back-to-back
      cfg_we = 0; req_valid = 1; req_addr = 16'h1100; req_write = 0; req_priv = 0; strict_mode = 0;
      step("R10 burst a");
      req_addr = 16'hFF80; req_priv = 1;
      step("R10 burst b");
      idle();
      step("R10 idle after burst");
      // Mixed random traffic
      for (int n = 0; n < 2000; n++) begin
         cfg_we    = ($urandom_range(0, 3) == 0);
         cfg_sel   = 2'($urandom_range(0, 3));
         cfg_kind  = $urandom_range(0, 1) != 0;
         cfg_priv  = $urandom_range(0, 1) != 0;
         cfg_wdata = cfg_kind ? 32'($urandom_range(0, 15))
                              : {16'($urandom_range(0, 16'h2000)), 16'($urandom_range(0, 16'h3000))};
         req_valid   = $urandom_range(0, 3) != 0;
         req_addr    = 16'($urandom_range(0, 16'h5000));
         req_write   = $urandom_range(0, 1) != 0;
         req_priv    = $urandom_range(0, 1) != 0;
         strict_mode = $urandom_range(0, 1) != 0;
         step("R7 R8 random mix");
      end
      idle();
      step("R10 final idle");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule